// File: doc/BRIEF.md
# Selectable Read Output Pipeline

This block is the read-data and bus-enable stage at the edge of a synchronous burst memory. Each clock it captures one command (idle/continue, read, write or deselect) into its input register. In the cycle after a read is captured, the storage array presents that read's data on `arr_rdata_i`. The block then decides, cycle by cycle, whether the data bus is driven and with which word. Two static mode inputs shape the timing. One picks flow-through or registered output. The other picks how many stages a deselect travels before the bus turns off.

Data leaves the block as a stream whose valid qualifier is `dq_en_o`. There is no ready. A memory bus cannot stall, so back-pressure is not supported, and the receiver must take each word in the cycle it is driven. Commands have no handshake either: a command is accepted at every rising edge. An asynchronous enable input sits in front of the bus and can silence it at any time without disturbing the internal pipeline.

The mode inputs may change only while reset is held.

Top module: `rd_out_pipe`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `dq_en_o` is 0.
- R2: Command encoding on `cmd_i`: 2'b00 idle/continue, 2'b01 read, 2'b10 write, 2'b11 deselect. With `flow_sel_i`=1 (flow-through), a read captured at edge n drives `dq_o` with the `arr_rdata_i` value of cycle n, in cycle n. Cycle n is the cycle following edge n, so the first access takes two clocks.
- R3: With `flow_sel_i`=0 (registered output), a read captured at edge n drives the array word of cycle n in cycle n+1, so the first access takes three clocks.
- R4: With `dcd_sel_i`=0 (single-stage deselect), a deselect captured at edge n turns the bus off in cycles n and n+1. A read slot in either cycle takes priority.
- R5: With `dcd_sel_i`=1 (two-stage deselect), a deselect captured at edge n leaves cycle n with the bus state and word of cycle n-1, and turns the bus off in cycle n+1. A read slot in cycle n+1 takes priority.
- R6: A read whose output slot falls in a cycle where a deselect turn-off is pending drives its data normally.
- R7: A write captured at edge n keeps the bus off in cycle n, its data-in cycle, in both output modes. This holds even over a registered-read slot.
- R8: An idle/continue command with no other rule acting repeats the previous cycle's bus state and word.
- R9: When `oe_i` is low, `dq_en_o` is 0 immediately, without waiting for a clock edge; `oe_i` has no effect on the pipeline.
- R10: With both mode inputs at 0 (their tie-off level), the block behaves as registered output with single-stage deselect.
- R11: Reads on consecutive edges produce one new word per clock with the bus driven throughout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flow_sel_i | input | 1 | 1 = flow-through output, 0 = registered output (static) |
| dcd_sel_i | input | 1 | 1 = two-stage deselect, 0 = single-stage deselect (static) |
| oe_i | input | 1 | Asynchronous bus enable, active high |
| cmd_i | input | 2 | Command captured at each rising edge |
| arr_rdata_i | input | DATA_W | Array read word, valid in the cycle after a read is captured |
| dq_o | output | DATA_W | Data bus value |
| dq_en_o | output | 1 | Bus drive enable; doubles as the stream valid |

## Verification
The bench targets three kinds of collision: a deselect right after a read, a deselect after a held (idle) cycle, and a read immediately after a deselect. It runs these in all four mode combinations. A design that confused the two deselect depths would cut off or extend the held bus by one cycle. A design that let a pending turn-off beat a read would lose a word. Writes are placed just behind registered reads, where a design that let the read win would drive the bus during write data-in. Dropping `oe_i` in mid-cycle catches an enable that was made synchronous.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_READ  = 2'b01,
    CMD_WRITE = 2'b10,
    CMD_DESEL = 2'b11
  } rop_cmd_e;
endpackage

// File: rtl/rop_cmd_stage.sv
// Input register (stage 1) and its one-cycle-older copy (stage 2).
module rop_cmd_stage
  import rop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic [1:0] cmd_i,
  output rop_cmd_e s1_o,
  output rop_cmd_e s2_o
);
  rop_cmd_e s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= CMD_NOP;
      s2_q <= CMD_NOP;
    end else begin
      s1_q <= rop_cmd_e'(cmd_i);
      s2_q <= s1_q;
    end
  end

  assign s1_o = s1_q;
  assign s2_o = s2_q;
endmodule

// File: rtl/rop_drive_ctl.sv
// Decides per cycle whether the bus is driven: write > read slot > turn-off > hold.
module rop_drive_ctl
  import rop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     flow_sel_i,
  input  logic     dcd_sel_i,
  input  rop_cmd_e s1_i,
  input  rop_cmd_e s2_i,
  output logic     rd_now_o,
  output logic     drv_o
);
  logic hold_q;
  logic wr_now, rd_now, off_now, drv;

  always_comb begin
    wr_now  = (s1_i == CMD_WRITE);
    rd_now  = flow_sel_i ? (s1_i == CMD_READ) : (s2_i == CMD_READ);
    off_now = (s2_i == CMD_DESEL) || (!dcd_sel_i && (s1_i == CMD_DESEL));
    if (wr_now)       drv = 1'b0;
    else if (rd_now)  drv = 1'b1;
    else if (off_now) drv = 1'b0;
    else              drv = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= drv;
  end

  assign rd_now_o = rd_now && !wr_now;
  assign drv_o    = drv;
endmodule

// File: rtl/rop_data_stage.sv
// Output data register plus flow-through bypass and held-word register.
module rop_data_stage #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_sel_i,
  input  logic              cap_i,
  input  logic              rd_now_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] preg_q, held_q, cur;

  always_comb begin
    if (rd_now_i) cur = flow_sel_i ? arr_rdata_i : preg_q;
    else          cur = held_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preg_q <= '0;
      held_q <= '0;
    end else begin
      if (cap_i) preg_q <= arr_rdata_i;
      held_q <= cur;
    end
  end

  assign data_o = cur;
endmodule

// File: rtl/rd_out_pipe.sv
module rd_out_pipe
  import rop_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flow_sel_i,
  input  logic              dcd_sel_i,
  input  logic              oe_i,
  input  logic [1:0]        cmd_i,
  input  logic [DATA_W-1:0] arr_rdata_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_en_o
);
  rop_cmd_e s1, s2;
  logic     rd_now, drv;

  rop_cmd_stage u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .s1_o(s1), .s2_o(s2)
  );

  rop_drive_ctl u_drv (
    .clk(clk), .rst_n(rst_n), .flow_sel_i(flow_sel_i), .dcd_sel_i(dcd_sel_i),
    .s1_i(s1), .s2_i(s2), .rd_now_o(rd_now), .drv_o(drv)
  );

  rop_data_stage #(.DATA_W(DATA_W)) u_dat (
    .clk(clk), .rst_n(rst_n), .flow_sel_i(flow_sel_i),
    .cap_i(s1 == CMD_READ), .rd_now_i(rd_now),
    .arr_rdata_i(arr_rdata_i), .data_o(dq_o)
  );

  assign dq_en_o = drv && oe_i;

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_i |-> !dq_en_o);

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_i == 2'b10) |=> !drv);

  // R2
  flow_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flow_sel_i && cmd_i == 2'b01) |=> (drv && dq_o == arr_rdata_i));

  // R3
  pipe_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow_sel_i && $past(cmd_i) == 2'b01 && cmd_i != 2'b10)
      |=> (drv && dq_o == $past(arr_rdata_i)));

  // R4
  scd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dcd_sel_i && cmd_i == 2'b11 && (flow_sel_i || $past(cmd_i) != 2'b01))
      |=> !drv);

  // R5
  dcd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dcd_sel_i && $past(cmd_i) == 2'b11 && !(flow_sel_i && cmd_i == 2'b01))
      |=> !drv);
endmodule

// File: tb/sim_rd_out_pipe.sv
module sim_rd_out_pipe;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flow_sel_i = 1'b0, dcd_sel_i = 1'b0, oe_i = 1'b1;
  logic [1:0] cmd_i = 2'b00;
  logic [W-1:0] arr_rdata_i = '0;
  logic [W-1:0] dq_o;
  logic dq_en_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rd_out_pipe #(.DATA_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .flow_sel_i(flow_sel_i), .dcd_sel_i(dcd_sel_i),
    .oe_i(oe_i), .cmd_i(cmd_i), .arr_rdata_i(arr_rdata_i),
    .dq_o(dq_o), .dq_en_o(dq_en_o)
  );

  // Reference model state: commands/data of this and last cycle, bus held state.
  logic [1:0]   c_cur, c_prev;
  logic [W-1:0] d_cur, d_prev, e_dat;
  bit           e_drv;
  logic [1:0]   plan[$];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic do_reset(input bit fl, input bit dc);
    @(negedge clk);
    rst_n = 1'b0;
    cmd_i = 2'b00;
    flow_sel_i = fl;
    dcd_sel_i = dc;
    repeat (2) @(negedge clk);
    #1 check(dq_en_o == 1'b0, "R1", dq_en_o, 0);
    rst_n = 1'b1;
    c_cur = 2'b00; c_prev = 2'b00;
    d_cur = '0; d_prev = '0; e_dat = '0; e_drv = 0;
  endtask

  // One cycle: called right after a negedge; c_cur is the command captured at the last edge.
  task automatic step(input logic [1:0] nxt, input bit oe_test);
    bit wr, rd, off;
    logic [W-1:0] rdat;
    string tag;
    d_cur = W'($urandom);
    arr_rdata_i = d_cur;
    wr  = (c_cur == 2'b10);
    rd  = flow_sel_i ? (c_cur == 2'b01) : (c_prev == 2'b01);
    rdat = flow_sel_i ? d_cur : d_prev;
    off = (c_prev == 2'b11) || (!dcd_sel_i && c_cur == 2'b11);
    if (wr)       begin e_drv = 0; tag = "R7"; end
    else if (rd)  begin e_drv = 1; e_dat = rdat; tag = flow_sel_i ? "R2/R6/R11" : "R3/R6/R11"; end
    else if (off) begin e_drv = 0; tag = dcd_sel_i ? "R5" : "R4"; end
    else          tag = "R8";
    if (!flow_sel_i && !dcd_sel_i) tag = {tag, " R10"};
    cmd_i = nxt;
    #1;
    check(dq_en_o == e_drv, tag, dq_en_o, e_drv);
    if (e_drv) check(dq_o == e_dat, tag, dq_o, e_dat);
    if (oe_test && e_drv) begin
      oe_i = 1'b0;
      #1 check(dq_en_o == 1'b0, "R9", dq_en_o, 0);
      oe_i = 1'b1;
      #1 check(dq_en_o == 1'b1, "R9", dq_en_o, 1);
    end
    c_prev = c_cur; d_prev = d_cur; c_cur = nxt;
    @(negedge clk);
  endtask

  task automatic run_mode(input bit fl, input bit dc);
    do_reset(fl, dc);
    plan = {2'b01, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00,   // held read, then deselect
            2'b01, 2'b11, 2'b00, 2'b00,                 // deselect right after read
            2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 2'b11,   // burst
            2'b11, 2'b01, 2'b00, 2'b11, 2'b00,          // read right after deselect
            2'b01, 2'b10, 2'b00, 2'b01, 2'b00, 2'b10,   // write behind read, write after hold
            2'b00, 2'b00};
    foreach (plan[i]) step(plan[i], (i == 13));
    for (int k = 0; k < 160; k++) step(2'($urandom), (k % 37 == 5));
  endtask

  initial begin
    run_mode(1'b0, 1'b0);
    run_mode(1'b0, 1'b1);
    run_mode(1'b1, 1'b0);
    run_mode(1'b1, 1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule